// File: doc/BRIEF.md
# Programmable I2C Bus Step Sequencer

This block is an I2C master that does not understand bytes, addresses or acknowledges at all. Instead, the host loads a chain of bus steps into a step memory. Each step fixes the level the master pulls onto SCL and SDA, can ask for SDA to be sampled, and names the step that follows. When started, the sequencer walks the chain from entry 0. It holds each step on the pins for a fixed number of system clocks. The run ends after a step whose link field is zero. Start conditions, data bits, acknowledge slots, repeated starts and stop conditions are all built by the host from short step recipes:

- a written bit is three steps with SDA held steady: SCL low, SCL high, SCL low;
- a read bit is four steps with SDA released: SCL low, SCL high, SCL high with sampling, SCL low;
- a start is SCL and SDA released, then SDA pulled low, then SCL pulled low;
- a stop is both lines low, then SCL released, then SDA released.

Bytes travel MSB first. Each byte is followed by an acknowledge slot. The master releases SDA in that slot after a byte it writes. After each byte it reads, the master drives ACK, except after the last byte, where it sends NACK.

Step entries arrive on a valid/ready stream. `prog_ready` is high exactly while the sequencer is idle. An entry offered during a run is held off, and it must stay stable on `prog_entry` until a cycle with both `prog_valid` and `prog_ready` high. Both bus lines are open-drain: the block only produces pull-low enables and reads SDA back through `sda_in`. Every bit sampled during a run is shifted into a readback register, from which the host takes the received bytes once `busy` has fallen.

Top module: `i2c_step_seq`

## Requirements
- R1: A step entry is accepted when `prog_valid` and `prog_ready` are both high, and `prog_ready` is high only while idle. The entry fields are: bits [27:18] the slot it is stored in, bit 13 drive enable, bit 12 sample enable, bit 11 SCL pulled low when 1, bit 10 SDA pulled low when 1, bits [9:0] the link to the next slot. All other bits are ignored.
- R2: A `start` pulse while idle begins a run at slot 0, and `busy` is high from the next cycle. A `start` pulse during a run has no effect.
- R3: Each step keeps its pin drive for exactly STEP_CLKS clock cycles.
- R4: After a step ends, the slot named by its link is executed next. The run ends after a step whose link is 0, so a run of N steps keeps `busy` high for N*STEP_CLKS cycles.
- R5: During a step, `scl_oe` equals drive AND SCL-low, and `sda_oe` equals drive AND SDA-low. A step with drive enable 0 releases both lines.
- R6: After reset, and whenever the sequencer is idle, `busy`, `scl_oe` and `sda_oe` are 0. After reset the readback register is 0.
- R7: In the last clock of a step that has sample enable set, `sda_in` is shifted into bit 0 of `rb_data`, and earlier bits move up one place. `rb_data` is cleared when a run starts and changes at no other time.
- R8: A chain built from the bit, start and stop recipes carries out a complete write-then-read transaction with a standard I2C target. The target sees its 7-bit address and the written data byte and acknowledges them. The received bytes appear MSB first in `rb_data`. The master acknowledges every read byte except the last, which gets NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_valid | input | 1 | Step entry offered |
| prog_ready | output | 1 | Step entry can be taken (idle) |
| prog_entry | input | 32 | Step entry word |
| start | input | 1 | Begin a run at slot 0 |
| busy | output | 1 | Run in progress |
| rb_data | output | RB_W | Sampled read bits, newest in bit 0 |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The hardest behaviour to reach from the ports is the target driving SDA mid-chain. This happens in the address and data acknowledge slots and in the bits of the bytes it returns. Only a complete, correctly ordered chain of about 160 steps ever makes a target respond. The bench therefore holds a behavioural I2C target on a wired-AND bus. It assembles the chain from the bit, start and stop recipes, and checks both sides: what the target received and acknowledged, and what landed in `rb_data`. Single-step runs over all sixteen flag combinations and a linked three-step chain, restarted mid-run, cover the step timing and pin encoding separately.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  // Field positions inside a step entry word
  localparam int ENTRY_SLOT_LSB = 18;
  localparam int ENTRY_FLAG_LSB = 10;
  localparam int ENTRY_FLAG_W   = 4;

  // Flag nibble, MSB first: bit 13 .. bit 10 of the entry
  typedef struct packed {
    logic drive;   // 0: release both lines for this step
    logic sample;  // shift SDA into readback at step end
    logic scl_lo;  // pull SCL low
    logic sda_lo;  // pull SDA low
  } step_flags_t;
endpackage

// File: rtl/i2c_seq_mem.sv
module i2c_seq_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int STEP_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign last = run && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || last)    cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_seq_rb.sv
module i2c_seq_rb #(
  parameter int RB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            bit_in,
  output logic [RB_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data <= '0;
    else if (clr)   data <= '0;
    else if (shift) data <= {data[RB_W-2:0], bit_in};
  end
endmodule

// File: rtl/i2c_step_seq.sv
module i2c_step_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int STEP_CLKS = 4,
  parameter int RB_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_valid,
  output logic            prog_ready,
  input  logic [31:0]     prog_entry,
  input  logic            start,
  output logic            busy,
  output logic [RB_W-1:0] rb_data,
  output logic            scl_oe,
  output logic            sda_oe,
  input  logic            sda_in
);
  localparam int SLOT_W = ENTRY_FLAG_W + ADDR_W;

  logic              running;
  step_flags_t       flags_q;
  logic [ADDR_W-1:0] link_q;
  logic [ADDR_W-1:0] fetch_addr;
  logic [SLOT_W-1:0] fetch_word;
  step_flags_t       fetch_flags;
  logic [ADDR_W-1:0] fetch_link;
  logic              step_end;
  logic              launch;
  logic              accept;
  logic              unused_fields;

  assign prog_ready = !running;
  assign accept     = prog_valid && prog_ready;
  assign launch     = start && !running;

  // Slot 0 is fetched to launch; during a run the pending link is fetched
  assign fetch_addr  = running ? link_q : '0;
  assign fetch_flags = step_flags_t'(fetch_word[SLOT_W-1 -: ENTRY_FLAG_W]);
  assign fetch_link  = fetch_word[ADDR_W-1:0];

  assign unused_fields = ^{prog_entry[31:ENTRY_SLOT_LSB+ADDR_W],
                           prog_entry[ENTRY_SLOT_LSB-1:ENTRY_FLAG_LSB+ENTRY_FLAG_W]};

  i2c_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(SLOT_W)) u_mem (
    .clk   (clk),
    .we    (accept),
    .waddr (prog_entry[ENTRY_SLOT_LSB +: ADDR_W]),
    .wdata ({prog_entry[ENTRY_FLAG_LSB +: ENTRY_FLAG_W], prog_entry[ADDR_W-1:0]}),
    .raddr (fetch_addr),
    .rdata (fetch_word)
  );

  i2c_seq_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .last  (step_end)
  );

  i2c_seq_rb #(.RB_W(RB_W)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .shift  (step_end && flags_q.sample),
    .bit_in (sda_in),
    .data   (rb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      flags_q <= '0;
      link_q  <= '0;
    end else if (launch) begin
      running <= 1'b1;
      flags_q <= fetch_flags;
      link_q  <= fetch_link;
    end else if (step_end) begin
      if (link_q == '0) begin
        running <= 1'b0;
        flags_q <= '0;
      end else begin
        flags_q <= fetch_flags;
        link_q  <= fetch_link;
      end
    end
  end

  assign busy   = running;
  assign scl_oe = flags_q.drive && flags_q.scl_lo;
  assign sda_oe = flags_q.drive && flags_q.sda_lo;
endmodule

// File: rtl/i2c_step_seq_chk.sv
module i2c_step_seq_chk #(
  parameter int STEP_CLKS = 4,
  parameter int RB_W      = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            prog_valid,
  input logic            prog_ready,
  input logic            busy,
  input logic            scl_oe,
  input logic            sda_oe,
  input logic [RB_W-1:0] rb_data
);
  localparam int CW = $clog2(STEP_CLKS + 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase <= '0;
    else if (!busy)                       phase <= '0;
    else if (phase == CW'(STEP_CLKS - 1)) phase <= '0;
    else                                  phase <= phase + 1'b1;
  end

  assert_no_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_ready) |-> !busy);

  assert_launch_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != '0) |-> ($stable(scl_oe) && $stable(sda_oe)));

  assert_run_whole_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(phase) == CW'(STEP_CLKS - 1)));

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_rb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != CW'(STEP_CLKS - 1)) |=> $stable(rb_data));
endmodule

bind i2c_step_seq i2c_step_seq_chk #(.STEP_CLKS(STEP_CLKS), .RB_W(RB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .prog_valid (prog_valid),
  .prog_ready (prog_ready),
  .busy       (busy),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .rb_data    (rb_data)
);

// File: tb/i2c_step_seq_bench.sv
module i2c_step_seq_bench;
  localparam int Q  = 4;
  localparam int RW = 32;
  localparam logic [6:0] TGT_ADR = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_valid = 1'b0;
  logic [31:0] prog_entry = '0;
  logic start = 1'b0;
  logic prog_ready, busy, scl_oe, sda_oe;
  logic [RW-1:0] rb_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // Open-drain bus with a target that never stretches the clock
  logic t_sda_oe = 1'b0;
  logic tgt_en = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || t_sda_oe);

  i2c_step_seq #(.ADDR_W(10), .STEP_CLKS(Q), .RB_W(RW)) u_i2c_step_seq (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_entry(prog_entry), .start(start), .busy(busy), .rb_data(rb_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural I2C target ----------------
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic t_act = 0, t_skip = 0, t_rd = 0, t_adph = 0, t_macked = 0, t_was_ad;
  int t_bit = 0;
  int t_acks = 0;
  logic [7:0] t_sh = '0, t_tx = '0, t_ptr = '0, t_rx = '0;
  logic [1:0] t_mack_log = '0;

  always @(scl_line or sda_line) begin
    if (tgt_en) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        t_act = 1; t_skip = 1; t_bit = 0; t_adph = 1; t_rd = 0; t_macked = 0; t_sda_oe = 0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        t_act = 0; t_sda_oe = 0;
      end else if (!p_scl && scl_line && t_act) begin
        if (t_bit < 8) t_sh = {t_sh[6:0], sda_line};
        else if (t_rd && !t_adph) begin
          t_macked = !sda_line;
          t_mack_log = {t_mack_log[0], !sda_line};
        end
      end else if (p_scl && !scl_line && t_act) begin
        if (t_skip) t_skip = 0;
        else begin
          t_bit++;
          if (t_bit == 8) begin
            if (t_adph) begin
              if (t_sh[7:1] == TGT_ADR) begin t_sda_oe = 1; t_acks++; t_rd = t_sh[0]; end
              else t_act = 0;
            end else if (!t_rd) begin
              t_rx = t_sh; t_ptr = t_sh; t_sda_oe = 1; t_acks++;
            end else t_sda_oe = 0;
          end else if (t_bit == 9) begin
            t_bit = 0; t_sda_oe = 0; t_was_ad = t_adph; t_adph = 0;
            if (t_rd && (t_was_ad || t_macked)) begin
              t_tx = t_ptr ^ 8'h3C; t_ptr = t_ptr + 8'd1; t_sda_oe = !t_tx[7];
            end
          end else if (t_rd && !t_adph) t_sda_oe = !t_tx[7 - t_bit];
        end
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  // ---------------- helpers ----------------
  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_entry(input int slot, input logic drv, input logic smp,
                          input logic scl, input logic sda, input int nxt);
    @(negedge clk);
    prog_valid = 1'b1;
    prog_entry = '0;
    prog_entry[27:18] = slot[9:0];
    prog_entry[13] = drv; prog_entry[12] = smp;
    prog_entry[11] = !scl; prog_entry[10] = !sda;
    prog_entry[9:0] = nxt[9:0];
    @(negedge clk);
    while (!prog_ready) @(negedge clk);
    prog_valid = 1'b0;
  endtask

  int pc = 0;
  task automatic put(input logic drv, input logic smp, input logic scl, input logic sda);
    wr_entry(pc, drv, smp, scl, sda, pc + 1);
    pc++;
  endtask
  task automatic wbit(input logic b);
    put(1, 0, 0, b); put(1, 0, 1, b); put(1, 0, 0, b);
  endtask
  task automatic rbit();
    put(1, 0, 0, 1); put(1, 0, 1, 1); put(1, 1, 1, 1); put(1, 0, 0, 1);
  endtask
  task automatic wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    wbit(1'b1);
  endtask
  task automatic rbyte(input logic last);
    for (int i = 0; i < 8; i++) rbit();
    wbit(last);
  endtask
  task automatic bus_start();
    put(1, 0, 1, 1); put(1, 0, 1, 0); put(1, 0, 0, 0);
  endtask

  // pulse start, count busy cycles; optional second pulse mid-run
  int run_len;
  logic [1:0] st_oe [8];
  task automatic run_seq(input bit poke);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    run_len = 0;
    while (busy && run_len < 5000) begin
      if (run_len % Q == 0 && run_len / Q < 8) st_oe[run_len / Q] = {scl_oe, sda_oe};
      if (poke && run_len == 5) start = 1'b1;
      if (poke && run_len == 6) start = 1'b0;
      if (run_len == 1) chk(!prog_ready, "R1 ready low while busy", prog_ready, 0);
      run_len++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(busy == 0, "R6 busy after reset", busy, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R6 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(rb_data == 0, "R6 readback after reset", rb_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_ready == 1, "R1 ready when idle", prog_ready, 1);

    // R3 R5 R7: sweep all flag combinations in a single-step run
    for (int f = 0; f < 16; f++) begin
      logic drv, smp, scl_lo, sda_lo;
      logic [1:0] e_oe;
      drv = f[3]; smp = f[2]; scl_lo = f[1]; sda_lo = f[0];
      wr_entry(0, drv, smp, !scl_lo, !sda_lo, 0);
      run_seq(0);
      e_oe = {drv & scl_lo, drv & sda_lo};
      chk(run_len == Q, "R3 single step length", run_len, Q);
      chk(st_oe[0] == e_oe, "R5 pin drive per flags", st_oe[0], e_oe);
      chk(rb_data == (smp ? RW'(!(drv & sda_lo)) : '0), "R7 sampled bit",
          rb_data, smp ? !(drv & sda_lo) : 0);
      chk(!scl_oe && !sda_oe, "R6 released after run", {scl_oe, sda_oe}, 0);
    end

    // R4 R2: linked chain 0 -> 3 -> 7 -> end, with a start pulse mid-run
    wr_entry(0, 1, 0, 0, 1, 3);
    wr_entry(3, 1, 1, 1, 0, 7);
    wr_entry(7, 0, 1, 0, 0, 0);
    run_seq(1);
    chk(run_len == 3 * Q, "R4 R2 chain length, restart ignored", run_len, 3 * Q);
    chk(st_oe[0] == 2'b10, "R4 step0 drive", st_oe[0], 2'b10);
    chk(st_oe[1] == 2'b01, "R4 step1 drive", st_oe[1], 2'b01);
    chk(st_oe[2] == 2'b00, "R5 drive-off step releases", st_oe[2], 2'b00);
    chk(rb_data == RW'(2'b01), "R7 two samples shifted", rb_data, 1);

    // R1: upper and middle entry bits are ignored
    @(negedge clk);
    prog_valid = 1'b1;
    prog_entry = 32'hF003_C000 | (32'd0 << 18) | (32'b1010 << 10);
    @(negedge clk); prog_valid = 1'b0;
    run_seq(0);
    chk(run_len == Q && st_oe[0] == 2'b10, "R1 stray bits ignored", {run_len, st_oe[0]}, {Q, 2'b10});

    // R8: write-then-read transaction against the target
    tgt_en = 1'b1;
    pc = 0;
    put(0, 0, 1, 1);
    bus_start();
    wbyte({TGT_ADR, 1'b0});
    wbyte(8'hA5);
    bus_start();
    wbyte({TGT_ADR, 1'b1});
    rbyte(1'b0);
    rbyte(1'b1);
    put(1, 0, 0, 0); put(1, 0, 1, 0);
    wr_entry(pc, 1, 0, 1, 1, 0);
    pc++;
    run_seq(0);
    chk(run_len == pc * Q, "R8 R4 transaction length", run_len, pc * Q);
    chk(t_rx == 8'hA5, "R8 target received data", t_rx, 8'hA5);
    chk(t_acks == 3, "R8 target acks", t_acks, 3);
    chk(rb_data == 32'h0000_999A, "R8 R7 read bytes MSB first", rb_data, 32'h999A);
    chk(t_mack_log == 2'b10, "R8 master ACK then NACK", t_mack_log, 2'b10);
    chk(t_act == 0, "R8 stop seen by target", t_act, 0);
    chk(!scl_oe && !sda_oe && sda_line, "R6 bus idle after transaction",
        {scl_oe, sda_oe, sda_line}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule